// File: doc/BRIEF.md
# Serial Frame Data Flag Generator

The block sits after a frame aligner and descrambler in a bit-serial receive path. It re-times the descrambled data bit by bit and drives four qualifier strobes next to it. These strobes tell the blocks downstream what each bit on the data output is. The frame is fixed at 728 bit slots, in this order: an 8-slot alignment word, 5 control slots, 11 additional-data slots and 704 payload slots. The first two alignment-word slots carry two control-information bits. The parity strobe marks those two slots as well as the control slots.

A bit-enable input advances the block by one slot. A frame-start pulse from the aligner restarts the slot count at slot 0. The block tracks whether the current frame is even or odd, so the payload strobe can follow a 2-bit mode selector. When the aligner reports loss of alignment, every strobe is forced low. The strobes stay low until the aligner issues a fresh frame start.

Top module: `frame_flag_gen`

## Requirements
- R1: While reset is asserted and after its release, data_out and all four flags are 0.
- R2: On every cycle with bit_en high, data_out takes the value of data_in. The new value appears after that clock edge.
- R3: A bit_en cycle with frame_start high presents slot 0. Each later bit_en cycle presents the next slot, and slot 0 follows slot 727. The first frame after a frame start that arrives while unsynchronised, or away from slot 727, is even. Reaching slot 0 from slot 727 flips the frame between even and odd, with or without a frame-start pulse.
- R4: flag_faw is high exactly in slots 0 to 7.
- R5: flag_par is high exactly in slots 0, 1 and 8 to 12.
- R6: flag_ad is high exactly in slots 13 to 23. flag_faw, flag_ad and flag_dv are never high together.
- R7: flag_dv covers slots 24 to 727 and depends on mode. Mode 2'b00 (stereo) and mode 2'b10 (data) flag these slots in every frame. Mode 2'b01 (mono) flags them only in odd frames. Mode 2'b11 never flags them.
- R8: A bit_en cycle with aligned low presents all flags at 0. The flags then stay 0 until a bit_en cycle with frame_start and aligned both high.
- R9: After reset, all flags stay 0 until the first frame-start pulse.
- R10: While bit_en is low, data_out, the flags and the slot position all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advances the block by one bit slot |
| frame_start | input | 1 | Aligner pulse marking slot 0 of a frame |
| aligned | input | 1 | High while the aligner holds frame lock |
| mode | input | 2 | Payload mode: 00 stereo, 01 mono, 10 data, 11 none |
| data_in | input | 1 | Descrambled serial data bit |
| data_out | output | 1 | Re-timed serial data bit |
| flag_faw | output | 1 | Alignment-word slot strobe |
| flag_par | output | 1 | Parity-protected control slot strobe |
| flag_ad | output | 1 | Additional-data slot strobe |
| flag_dv | output | 1 | Mode-qualified payload strobe |

## Verification
All results are due one clock edge after the bit_en cycle that carries the stimulus. This holds for the slot strobes, the inhibit from a low aligned and the re-timed data bit. The bench drives each input at a falling edge and lets one rising edge pass. It compares at the next falling edge. To reach a slot, the bench counts bit_en edges from a frame-start pulse, so slot n of frame f is checked after exactly 728*f+n further edges. The hold checks leave bit_en low for several cycles. They then confirm that the outputs are unchanged and that the next enabled edge lands on the following slot.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

   typedef enum logic [1:0] {
      MODE_STEREO = 2'b00,
      MODE_MONO   = 2'b01,
      MODE_DATA   = 2'b10,
      MODE_NONE   = 2'b11
   } fdf_mode_e;

   typedef struct packed {
      logic faw;
      logic par;
      logic ad;
      logic dv;
   } fdf_flags_t;

endpackage

// File: rtl/fdf_slot_counter.sv
module fdf_slot_counter #(
   parameter int FRAME_LEN = 728,
   parameter int CW        = $clog2(FRAME_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          frame_start,
   input  logic          aligned,
   output logic [CW-1:0] slot_nxt,
   output logic          odd_nxt,
   output logic          sync_nxt
);

   localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

   logic [CW-1:0] slot_q;
   logic          odd_q;
   logic          sync_q;
   logic          at_last;

   assign at_last = (slot_q == LAST);

   always_comb begin
      if (frame_start) begin
         slot_nxt = '0;
         odd_nxt  = (at_last && sync_q) ? ~odd_q : 1'b0;
      end else if (at_last) begin
         slot_nxt = '0;
         odd_nxt  = ~odd_q;
      end else begin
         slot_nxt = slot_q + CW'(1);
         odd_nxt  = odd_q;
      end
      sync_nxt = aligned & (frame_start | sync_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         odd_q  <= 1'b0;
         sync_q <= 1'b0;
      end else if (bit_en) begin
         slot_q <= slot_nxt;
         odd_q  <= odd_nxt;
         sync_q <= sync_nxt;
      end
   end

   a_r3_wrap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !frame_start && slot_q == LAST) |=> (slot_q == '0 && odd_q != $past(odd_q)));

   a_r3_start_even: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && frame_start && !sync_q) |=> (slot_q == '0 && !odd_q));

   a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en) |=> ($stable(slot_q) && $stable(odd_q)));

   a_r8_sync_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !aligned) |=> !sync_q);

endmodule

// File: rtl/fdf_slot_decoder.sv
module fdf_slot_decoder
   import fdf_pkg::*;
#(
   parameter int FRAME_LEN   = 728,
   parameter int FAW_LEN     = 8,
   parameter int CIB_LEN     = 2,
   parameter int CTRL_LEN    = 5,
   parameter int AD_LEN      = 11,
   parameter bit MONO_ON_ODD = 1'b1,
   parameter int CW          = $clog2(FRAME_LEN)
) (
   input  logic [CW-1:0] slot,
   input  logic          odd,
   input  logic [1:0]    mode,
   output fdf_flags_t    flags
);

   localparam int CTRL_LO = FAW_LEN;
   localparam int AD_LO   = CTRL_LO + CTRL_LEN;
   localparam int PAY_LO  = AD_LO + AD_LEN;

   localparam logic [CW-1:0] S_CTRL = CW'(CTRL_LO);
   localparam logic [CW-1:0] S_AD   = CW'(AD_LO);
   localparam logic [CW-1:0] S_PAY  = CW'(PAY_LO);
   localparam logic [CW-1:0] S_LAST = CW'(FRAME_LEN - 1);

   fdf_mode_e mode_e;
   logic      in_faw, in_ctrl, in_ad, in_pay, in_cib;
   logic      mono_frame;

   assign mode_e  = fdf_mode_e'(mode);
   assign in_faw  = (slot < S_CTRL);
   assign in_ctrl = (slot >= S_CTRL) && (slot < S_AD);
   assign in_ad   = (slot >= S_AD) && (slot < S_PAY);
   assign in_pay  = (slot >= S_PAY) && (slot <= S_LAST);

   generate
      if (CIB_LEN == 0) begin : g_no_cib
         assign in_cib = 1'b0;
      end else begin : g_cib
         localparam logic [CW-1:0] S_CIB = CW'(CIB_LEN);
         assign in_cib = (slot < S_CIB);
      end

      if (MONO_ON_ODD) begin : g_mono_odd
         assign mono_frame = odd;
      end else begin : g_mono_even
         assign mono_frame = ~odd;
      end
   endgenerate

   always_comb begin
      flags.faw = in_faw;
      flags.par = in_cib | in_ctrl;
      flags.ad  = in_ad;
      unique case (mode_e)
         MODE_STEREO: flags.dv = in_pay;
         MODE_DATA:   flags.dv = in_pay;
         MODE_MONO:   flags.dv = in_pay & mono_frame;
         default:     flags.dv = 1'b0;
      endcase
   end

endmodule

// File: rtl/fdf_out_stage.sv
module fdf_out_stage
   import fdf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       aligned,
   input  logic       sync_nxt,
   input  fdf_flags_t flags_in,
   input  logic       data_in,
   output logic       data_out,
   output fdf_flags_t flags_q
);

   logic qualify;
   assign qualify = aligned & sync_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= 1'b0;
         flags_q  <= '0;
      end else if (bit_en) begin
         data_out <= data_in;
         flags_q  <= qualify ? flags_in : '0;
      end
   end

   a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !aligned) |=> (flags_q == '0));

   a_r2_retime: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |=> (data_out == $past(data_in)));

   a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en) |=> ($stable(flags_q) && $stable(data_out)));

endmodule

// File: rtl/frame_flag_gen.sv
module frame_flag_gen
   import fdf_pkg::*;
#(
   parameter int FRAME_LEN   = 728,
   parameter int FAW_LEN     = 8,
   parameter int CIB_LEN     = 2,
   parameter int CTRL_LEN    = 5,
   parameter int AD_LEN      = 11,
   parameter bit MONO_ON_ODD = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       frame_start,
   input  logic       aligned,
   input  logic [1:0] mode,
   input  logic       data_in,
   output logic       data_out,
   output logic       flag_faw,
   output logic       flag_par,
   output logic       flag_ad,
   output logic       flag_dv
);

   localparam int CW       = $clog2(FRAME_LEN);
   localparam int OVERHEAD = FAW_LEN + CTRL_LEN + AD_LEN;

   generate
      if (CIB_LEN > FAW_LEN) begin : g_bad_cib
         $error("frame_flag_gen: CIB_LEN must not exceed FAW_LEN");
      end
      if (FAW_LEN < 1) begin : g_bad_faw
         $error("frame_flag_gen: FAW_LEN must be at least 1");
      end
      if (OVERHEAD >= FRAME_LEN) begin : g_bad_len
         $error("frame_flag_gen: overhead must leave payload slots");
      end
   endgenerate

   logic [CW-1:0] slot_nxt;
   logic          odd_nxt;
   logic          sync_nxt;
   fdf_flags_t    dec_flags;
   fdf_flags_t    out_flags;

   fdf_slot_counter #(
      .FRAME_LEN (FRAME_LEN),
      .CW        (CW)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .frame_start (frame_start),
      .aligned     (aligned),
      .slot_nxt    (slot_nxt),
      .odd_nxt     (odd_nxt),
      .sync_nxt    (sync_nxt)
   );

   fdf_slot_decoder #(
      .FRAME_LEN   (FRAME_LEN),
      .FAW_LEN     (FAW_LEN),
      .CIB_LEN     (CIB_LEN),
      .CTRL_LEN    (CTRL_LEN),
      .AD_LEN      (AD_LEN),
      .MONO_ON_ODD (MONO_ON_ODD),
      .CW          (CW)
   ) u_dec (
      .slot  (slot_nxt),
      .odd   (odd_nxt),
      .mode  (mode),
      .flags (dec_flags)
   );

   fdf_out_stage u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .aligned  (aligned),
      .sync_nxt (sync_nxt),
      .flags_in (dec_flags),
      .data_in  (data_in),
      .data_out (data_out),
      .flags_q  (out_flags)
   );

   assign flag_faw = out_flags.faw;
   assign flag_par = out_flags.par;
   assign flag_ad  = out_flags.ad;
   assign flag_dv  = out_flags.dv;

   a_r6_regions_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_faw, flag_ad, flag_dv}));

   a_r5_par_in_overhead: assert property (@(posedge clk) disable iff (!rst_n)
      flag_par |-> (!flag_ad && !flag_dv));

   a_r9_no_flags_in_reset: assert property (@(posedge clk)
      !rst_n |-> ({flag_faw, flag_par, flag_ad, flag_dv} == 4'b0000));

endmodule

// File: tb/frame_flag_gen_test.sv
module frame_flag_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int FLEN       = 728;
   localparam int NVEC       = 20;

   // {mode[1:0], odd, slot[9:0], expected {faw,par,ad,dv}}
   localparam logic [16:0] VEC [NVEC] = '{
      {2'b00, 1'b0, 10'd0,   4'b1100},   // R4 R5
      {2'b00, 1'b0, 10'd1,   4'b1100},   // R5
      {2'b00, 1'b0, 10'd2,   4'b1000},   // R4
      {2'b00, 1'b0, 10'd7,   4'b1000},   // R4
      {2'b00, 1'b0, 10'd8,   4'b0100},   // R5
      {2'b00, 1'b0, 10'd12,  4'b0100},   // R5
      {2'b00, 1'b0, 10'd13,  4'b0010},   // R6
      {2'b00, 1'b0, 10'd23,  4'b0010},   // R6
      {2'b00, 1'b0, 10'd24,  4'b0001},   // R7
      {2'b00, 1'b0, 10'd727, 4'b0001},   // R7
      {2'b00, 1'b1, 10'd0,   4'b1100},   // R3 wrap
      {2'b01, 1'b0, 10'd24,  4'b0000},   // R7 mono even
      {2'b01, 1'b0, 10'd727, 4'b0000},   // R7
      {2'b01, 1'b1, 10'd24,  4'b0001},   // R7 mono odd
      {2'b01, 1'b1, 10'd500, 4'b0001},   // R7
      {2'b10, 1'b0, 10'd300, 4'b0001},   // R7 data
      {2'b10, 1'b1, 10'd727, 4'b0001},   // R7
      {2'b11, 1'b0, 10'd100, 4'b0000},   // R7 none
      {2'b11, 1'b1, 10'd13,  4'b0010},   // R6
      {2'b01, 1'b1, 10'd12,  4'b0100}    // R5
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic       frame_start;
   logic       aligned;
   logic [1:0] mode;
   logic       data_in;
   logic       data_out;
   logic       flag_faw, flag_par, flag_ad, flag_dv;

   int applied = 0;
   int errors  = 0;
   int nstep   = 0;
   logic last_din = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_flag_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .frame_start (frame_start),
      .aligned     (aligned),
      .mode        (mode),
      .data_in     (data_in),
      .data_out    (data_out),
      .flag_faw    (flag_faw),
      .flag_par    (flag_par),
      .flag_ad     (flag_ad),
      .flag_dv     (flag_dv)
   );

   task automatic check(input string req, input logic [3:0] exp_f, input logic exp_d);
      logic [3:0] act;
      act = {flag_faw, flag_par, flag_ad, flag_dv};
      applied++;
      if (act !== exp_f || data_out !== exp_d) begin
         errors++;
         $display("FAIL %s: flags=%b data=%b expected flags=%b data=%b",
                  req, act, data_out, exp_f, exp_d);
      end
   endtask

   // one bit_en edge; inputs set at falling edge, outputs read at next falling edge
   task automatic step(input logic fs);
      nstep++;
      frame_start = fs;
      bit_en      = 1'b1;
      data_in     = nstep[0] ^ nstep[3];
      last_din    = data_in;
      @(posedge clk);
      @(negedge clk);
      frame_start = 1'b0;
      bit_en      = 1'b0;
   endtask

   task automatic advance(input int n);
      for (int i = 0; i < n; i++) step(1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bit_en = 1'b0; frame_start = 1'b0;
      aligned = 1'b1; mode = 2'b00; data_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
   end

   initial begin
      do_reset();
      check("R1 reset state", 4'b0000, 1'b0);

      // R9: running without a frame start raises no flag, data still passes (R2)
      advance(5);
      check("R9 unsynced", 4'b0000, last_din);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         logic [16:0] e;
         e = VEC[v];
         do_reset();
         mode = e[16:15];
         step(1'b1);
         advance(int'(e[14]) * FLEN + int'(e[13:4]));
         check($sformatf("R3-R7 vector %0d", v), e[3:0], last_din);
      end

      // R10: hold while bit_en low, then resume on the next slot
      do_reset();
      step(1'b1);
      advance(12);
      repeat (4) @(negedge clk);
      check("R10 hold slot 12", 4'b0100, last_din);
      step(1'b0);
      check("R10 resume slot 13", 4'b0010, last_din);

      // R8: alignment loss inhibits flags until next frame start
      do_reset();
      step(1'b1);
      advance(2);
      aligned = 1'b0;
      step(1'b0);
      check("R8 inhibit at slot 3", 4'b0000, last_din);
      aligned = 1'b1;
      advance(2);
      check("R8 stays dark after relock", 4'b0000, last_din);
      step(1'b1);
      check("R8 restart slot 0", 4'b1100, last_din);

      // R3: mid-frame restart in mono mode returns to an even frame
      do_reset();
      mode = 2'b01;
      step(1'b1);
      advance(FLEN + 30);
      check("R3 mono odd payload", 4'b0001, last_din);
      step(1'b1);
      check("R3 restart slot 0", 4'b1100, last_din);
      advance(24);
      check("R3 restart frame is even", 4'b0000, last_din);

      // R3: a frame start at the natural boundary still toggles to odd
      do_reset();
      mode = 2'b01;
      step(1'b1);
      advance(FLEN - 1);
      step(1'b1);
      advance(24);
      check("R3 boundary start toggles", 4'b0001, last_din);

      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
   end

endmodule